// File: doc/BRIEF.md
# Serial Flash Page-Buffer Command Slave

This block is the serial command front end of a data-flash style device. It holds two on-chip page buffers of 264 bytes each and answers two kinds of read command. A host on a mode 0/3 serial link selects the block by pulling chip-select low. It then clocks in an 8-bit command code on the serial input, followed by any header bits. The block answers on the serial output, either with bytes from one of the page buffers or with the device status byte. It keeps answering until chip-select is released.

All serial lines are sampled into the block's own system clock domain, so SCK must run at no more than about a tenth of the system clock. A byte-wide parallel port fills the page buffers before serial access, which lets a test load known contents. The output is a data bit plus a separate drive enable, so a pad or bench can build the tri-state line.

Top module: `sfb_slave`

## Requirements
- R1: A command starts when chip-select falls. The next 8 SI bits, each sampled on a rising SCK edge and taken MSB first, form the command code.
- R2: Codes 54h and D4h read page buffer 0. Codes 56h and D6h read page buffer 1.
- R3: After a buffer-read code the block takes 32 header bits. Bits 0..14 are ignored, bits 15..23 are the 9-bit start address (MSB first), and bits 24..31 are ignored. The first data bit appears on the falling SCK edge after header bit 31. Data bytes go out MSB first, and SO changes only on falling SCK edges.
- R4: Buffer reads advance one byte at a time and wrap from byte 263 to byte 0.
- R5: A start address of 264 or more is reduced by 264.
- R6: Codes 57h and D7h return the status byte {status_i[4:0], 3'b000}. Its bit 7 appears on the falling SCK edge after the code's last bit.
- R7: The status byte repeats while chip-select stays low. Each new copy takes status_i as it stands when bit 0 of the previous copy is driven.
- R8: Any other code keeps so_oe_o low until chip-select rises. The next command after that decodes normally.
- R9: so_oe_o is low after reset and within 3 clocks of chip-select going high.
- R10: When ld_en_i is high, ld_data_i is written to buffer ld_sel_i at byte ld_addr_i. A write to an address of 264 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip-select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for so_o (0 = high impedance) |
| status_i | input | 5 | Device information placed in status bits 7..3 |
| ld_en_i | input | 1 | Parallel preload write strobe |
| ld_sel_i | input | 1 | Preload buffer select |
| ld_addr_i | input | 9 | Preload byte address |
| ld_data_i | input | 8 | Preload byte |

## Verification
The assertions assume that SCK and chip-select change slowly compared with the system clock. Under that assumption each serial edge shows up as a single sampled edge pulse. They also assume that preload writes and serial reads never reach the same byte at the same time. The bench holds each SCK level for 8 system clocks and changes SI only while SCK is low. It changes status_i only between serial edges, and it finishes all preloading before any transaction starts.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_HDR, ST_STAT, ST_DATA, ST_IGN
  } state_t;

  typedef enum logic [1:0] {
    CMD_BUF0, CMD_BUF1, CMD_STAT, CMD_BAD
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] code);
    case (code)
      8'h54, 8'hD4: return CMD_BUF0;
      8'h56, 8'hD6: return CMD_BUF1;
      8'h57, 8'hD7: return CMD_STAT;
      default:      return CMD_BAD;
    endcase
  endfunction
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= RST_VAL;
      s1_q <= RST_VAL;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end

  assign q_o = s1_q;
endmodule

// File: rtl/sfb_page_buf.sv
module sfb_page_buf #(
  parameter int unsigned DEPTH = 264,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (wr_addr_i < AW'(DEPTH))) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = (rd_addr_i < AW'(DEPTH)) ? mem_q[rd_addr_i] : 8'h00;
endmodule

// File: rtl/sfb_cmd_fsm.sv
module sfb_cmd_fsm
  import sfb_pkg::*;
#(
  parameter int unsigned DEPTH  = 264,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned PRE_W  = 15,
  parameter int unsigned POST_W = 8,
  parameter int unsigned STAT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              cs_fall_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_s_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [7:0]        rd_byte_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic              buf_sel_o,
  output logic              so_o,
  output logic              so_oe_o,
  output state_t            state_o,
  output logic [AW-1:0]     ptr_o
);
  localparam int unsigned HDR_BITS = PRE_W + AW + POST_W;
  localparam int unsigned CNT_W    = $clog2(HDR_BITS + 1);
  localparam int unsigned RSV_W    = 8 - STAT_W;

  state_t            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        opc_q;
  logic [AW-1:0]     addr_q, ptr_q, addr_wrap, next_ptr;
  logic              sel_q, so_q, oe_q;
  logic [7:0]        tx_q, stat_byte;
  logic [2:0]        tx_cnt_q;
  cmd_t              cmd;

  assign cmd       = decode_cmd({opc_q, si_s_i});
  assign addr_wrap = (addr_q >= AW'(DEPTH)) ? addr_q - AW'(DEPTH) : addr_q;
  assign next_ptr  = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign stat_byte = {status_i, {RSV_W{1'b0}}};
  assign rd_addr_o = (state_q == ST_HDR) ? addr_wrap : next_ptr;
  assign buf_sel_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      opc_q    <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      sel_q    <= 1'b0;
      so_q     <= 1'b0;
      oe_q     <= 1'b0;
      tx_q     <= '0;
      tx_cnt_q <= '0;
    end else if (cs_s_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (cs_fall_i) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_OPC: if (sck_rise_i) begin
          opc_q <= {opc_q[5:0], si_s_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(7)) begin
            cnt_q    <= '0;
            tx_cnt_q <= '0;
            unique case (cmd)
              CMD_BUF0: begin state_q <= ST_HDR; sel_q <= 1'b0; end
              CMD_BUF1: begin state_q <= ST_HDR; sel_q <= 1'b1; end
              CMD_STAT: begin state_q <= ST_STAT; tx_q <= stat_byte; end
              default:  state_q <= ST_IGN;
            endcase
          end
        end
        ST_HDR: if (sck_rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= CNT_W'(PRE_W) && cnt_q < CNT_W'(PRE_W + AW))
            addr_q <= {addr_q[AW-2:0], si_s_i};
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            ptr_q   <= addr_wrap;
            tx_q    <= rd_byte_i;
            state_q <= ST_DATA;
          end
        end
        ST_STAT, ST_DATA: if (sck_fall_i) begin
          so_q     <= tx_q[7];
          oe_q     <= 1'b1;
          tx_q     <= {tx_q[6:0], 1'b0};
          tx_cnt_q <= tx_cnt_q + 1'b1;
          if (tx_cnt_q == 3'd7) begin
            if (state_q == ST_STAT) begin
              tx_q <= stat_byte;
            end else begin
              tx_q  <= rd_byte_i;
              ptr_q <= next_ptr;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;
  assign state_o = state_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/sfb_slave.sv
module sfb_slave
  import sfb_pkg::*;
#(
  parameter int unsigned DEPTH  = 264,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned PRE_W  = 15,
  parameter int unsigned POST_W = 8,
  parameter int unsigned STAT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [STAT_W-1:0] status_i,
  input  logic              ld_en_i,
  input  logic              ld_sel_i,
  input  logic [AW-1:0]     ld_addr_i,
  input  logic [7:0]        ld_data_i
);
  localparam int unsigned NUM_BUF = 2;

  logic       cs_s, sck_s, si_s, cs_prev_q, sck_prev_q;
  logic       cs_fall, sck_rise, sck_fall, buf_sel;
  logic [AW-1:0] rd_addr, ptr;
  logic [7:0] rd_data [NUM_BUF];
  state_t     state;

  sfb_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, si_i}),
    .q_o    ({cs_s, sck_s, si_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      cs_prev_q  <= cs_s;
      sck_prev_q <= sck_s;
    end
  end

  assign cs_fall  = cs_prev_q & ~cs_s;
  assign sck_rise = ~sck_prev_q & sck_s;
  assign sck_fall = sck_prev_q & ~sck_s;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    sfb_page_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
      .clk_i     (clk_i),
      .we_i      (ld_en_i && (ld_sel_i == 1'(b))),
      .wr_addr_i (ld_addr_i),
      .wr_data_i (ld_data_i),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data[b])
    );
  end

  sfb_cmd_fsm #(
    .DEPTH(DEPTH), .AW(AW), .PRE_W(PRE_W), .POST_W(POST_W), .STAT_W(STAT_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .cs_fall_i  (cs_fall),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .si_s_i     (si_s),
    .status_i   (status_i),
    .rd_byte_i  (rd_data[buf_sel]),
    .rd_addr_o  (rd_addr),
    .buf_sel_o  (buf_sel),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .state_o    (state),
    .ptr_o      (ptr)
  );
endmodule

// File: rtl/sfb_slave_chk.sv
module sfb_slave_chk
  import sfb_pkg::*;
#(
  parameter int unsigned DEPTH = 264,
  parameter int unsigned AW    = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s,
  input logic          sck_fall,
  input logic          so_o,
  input logic          so_oe_o,
  input state_t        state,
  input logic [AW-1:0] ptr
);
  AST_OE_OFF_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s)) |-> !so_oe_o);  // R9

  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall |=> $stable(so_o));  // R3

  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr < AW'(DEPTH));  // R4

  AST_BAD_CODE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGN) |-> !so_oe_o);  // R8

  AST_OE_ONLY_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (state == ST_STAT || state == ST_DATA));  // R6
endmodule

bind sfb_slave sfb_slave_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .sck_fall (sck_fall),
  .so_o     (so_o),
  .so_oe_o  (so_oe_o),
  .state    (state),
  .ptr      (ptr)
);

// File: tb/sfb_slave_tb.sv
module sfb_slave_tb_top;
  localparam int DEPTH = 264;

  logic clk = 0, rst_ni = 0;
  logic sck = 0, cs_n = 1, si = 0;
  logic so, so_oe;
  logic [4:0] status = '0;
  logic ld_en = 0, ld_sel = 0;
  logic [8:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sfb_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .status_i(status),
    .ld_en_i(ld_en), .ld_sel_i(ld_sel), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  function automatic logic [7:0] pat(input int b, input int i);
    return (b == 0) ? 8'((i * 7 + 3) & 8'hFF) : 8'(((i * 13) ^ 8'h5A) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic o, output logic e);
    si = b;
    clks(8);
    o = so; e = so_oe;
    sck = 1;
    clks(8);
    sck = 0;
  endtask

  task automatic cs_start();
    cs_n = 0; clks(6);
  endtask

  task automatic cs_stop();
    clks(4); cs_n = 1; clks(6);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic o, e;
    for (int k = n - 1; k >= 0; k--) spi_bit(v[k], o, e);
  endtask

  task automatic recv_byte(output logic [7:0] d, output bit all_oe, output bit any_oe);
    logic o, e;
    all_oe = 1; any_oe = 0;
    for (int k = 7; k >= 0; k--) begin
      spi_bit(1'b0, o, e);
      d[k] = o;
      all_oe &= e; any_oe |= e;
    end
  endtask

  task automatic buf_read(input logic [7:0] code, input int addr, input int nb,
                          input int b, input int first_exp, input string req);
    logic [7:0] d; bit ao, an;
    cs_start();
    send_bits({24'd0, code}, 8);
    send_bits({15'h7FFF, 9'(addr), 8'hFF}, 32);
    for (int n = 0; n < nb; n++) begin
      int idx = (first_exp + n) % DEPTH;
      recv_byte(d, ao, an);
      check(ao && d == pat(b, idx), req, {ao, d}, {1'b1, pat(b, idx)});
    end
    cs_stop();
  endtask

  task automatic t_reset();
    check(so_oe == 0, "R9 reset", so_oe, 0);
  endtask

  task automatic t_preload();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        ld_en = 1; ld_sel = 1'(b); ld_addr = 9'(i); ld_data = pat(b, i);
        clks(1);
      end
    ld_en = 1; ld_sel = 0; ld_addr = 9'd264; ld_data = 8'hA5;
    clks(1);
    ld_en = 0; clks(2);
  endtask

  task automatic t_buffers();
    buf_read(8'h54, 5, 3, 0, 5, "R1 R2 R3 buf0 via 54h");
    buf_read(8'hD4, 100, 2, 0, 100, "R2 buf0 via D4h");
    buf_read(8'h56, 5, 3, 1, 5, "R2 buf1 via 56h");
    buf_read(8'hD6, 200, 2, 1, 200, "R2 buf1 via D6h");
  endtask

  task automatic t_wrap();
    buf_read(8'h54, 262, 4, 0, 262, "R4 wrap 263->0");
    buf_read(8'h56, 300, 2, 1, 36, "R5 addr 300 mod 264");
    buf_read(8'h54, 0, 1, 0, 0, "R10 write at 264 ignored");
  endtask

  task automatic t_status();
    logic [7:0] d; bit ao, an;
    status = 5'b10110;
    cs_start();
    send_bits(32'h57, 8);
    status = 5'b01001;
    recv_byte(d, ao, an);
    check(ao && d == 8'hB0, "R6 status first byte", d, 8'hB0);
    recv_byte(d, ao, an);
    check(ao && d == 8'h48, "R7 status repeat fresh", d, 8'h48);
    status = 5'b11111;
    recv_byte(d, ao, an);
    check(d == 8'h48, "R7 status third copy", d, 8'h48);
    recv_byte(d, ao, an);
    check(d == 8'hF8, "R7 status fourth copy", d, 8'hF8);
    cs_stop();
    status = 5'b00011;
    cs_start();
    send_bits(32'hD7, 8);
    recv_byte(d, ao, an);
    check(ao && d == 8'h18, "R6 status via D7h", d, 8'h18);
    cs_stop();
  endtask

  task automatic t_bad_code();
    logic [7:0] d; bit ao, an;
    cs_start();
    send_bits(32'h55, 8);
    for (int n = 0; n < 3; n++) begin
      recv_byte(d, ao, an);
      check(!an, "R8 bad code silent", an, 0);
    end
    send_bits(32'h57, 8);
    recv_byte(d, ao, an);
    check(!an, "R8 later code ignored", an, 0);
    cs_stop();
    buf_read(8'h56, 7, 1, 1, 7, "R8 recovery after bad code");
  endtask

  task automatic t_deselect();
    logic [7:0] d; bit ao, an;
    cs_start();
    send_bits(32'h54, 8);
    send_bits({15'h0, 9'd10, 8'h0}, 32);
    recv_byte(d, ao, an);
    check(so_oe == 1, "R9 driving before deselect", so_oe, 1);
    cs_n = 1;
    clks(3);
    check(so_oe == 0, "R9 off after deselect", so_oe, 0);
    clks(6);
  endtask

  initial begin
    clks(3);
    rst_ni = 1;
    clks(3);
    t_reset();
    t_preload();
    t_buffers();
    t_wrap();
    t_status();
    t_bad_code();
    t_deselect();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule